// File: doc/BRIEF.md
# Center-Aligned Three-Phase PWM Generator

This block drives the six gates of a two-level, three-phase voltage source inverter. A 16-bit up/down counter forms a symmetric triangular carrier. One switching period is a full climb from zero to the programmed peak and the descent back to zero. Each phase leg compares the carrier with its own duty value. The resulting on-window is centred on the carrier valley and becomes a complementary pair of upper and lower gate signals, separated by a dead gap.

A host writes the peak, the three duty values, an interrupt divisor and a protection enable over a write-only register bus. Duty values wait in shadow registers and reach the comparators only when the carrier is at a vertex (peak or valley). The peak is taken only at a valley, so a period is never cut short. The dead-gap length comes from a static configuration input, as board switches would set it. A level interrupt asks the host to run its control loop once every N carrier vertices. A fault input, while protection is enabled, latches a trip that holds all six gates low until software clears it.

Register addresses (wr_addr): 0 = peak, 1/2/3 = duty of leg 0/1/2, 4 = interrupt divisor N, 5 = protection enable (bit 0), 6 = command strobes (bit 0 clears the trip, bit 1 acknowledges the interrupt).

Top module: `pwm3_top`

## Requirements
- R1: The carrier runs 0,1,…,P,P-1,…,1,0 with a period of 2·P cycles, where P is the active peak. A peak written at address 0 becomes active at the next valley, and a written value of 0 is stored as 1.
- R2: In steady state, with peak P, duty D in 0<D<P and dead value T (with 2·D>T and 2·(P-D)>T), the upper gate of a leg is high for exactly 2·D−T cycles of every 2·P-cycle window, and the lower gate for 2·(P−D)−T cycles.
- R3: A duty of 0 keeps the upper gate low and the lower gate high for the whole period. A duty at or above P keeps the upper gate high and the lower gate low for the whole period.
- R4: A duty written at addresses 1–3 takes effect only at a carrier vertex. Every upper-gate pulse therefore has length D1+D2−T, where D1 and D2 are the duties active before and after one valley: 2·Dold−T, 2·Dnew−T or Dold+Dnew−T.
- R5: The upper and lower gates of one leg are never high together. After either gate turns off, its partner stays off for dead_cfg further cycles.
- R6: With dead_cfg equal to 0, the two gates of each leg are exact complements in every cycle.
- R7: While protection is enabled (address 5 bit 0 = 1, the reset value), a high fault_in sampled at a clock edge drives all six gates low from that edge onward. They stay low until a clear command (address 6 bit 0) is written while fault_in is low. A clear written while fault_in is high has no effect.
- R8: With protection disabled, fault_in has no effect on the gates.
- R9: With divisor N ≥ 1 (address 4), irq rises once every N carrier vertices, so successive rises are N·P cycles apart. irq stays high until an acknowledge (address 6 bit 1) is written. N = 0 produces no interrupt.
- R10: After reset all upper gates are low, all lower gates are high, irq is low and protection is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| dead_cfg | input | 8 | Static dead-gap length in clock cycles |
| fault_in | input | 1 | Fault request, active high |
| gate_hi | output | 3 | Upper switch gate per leg |
| gate_lo | output | 3 | Lower switch gate per leg |
| irq | output | 1 | Control-loop interrupt request, level |

## Verification
A wrong carrier count or direction shows up within one period as upper-gate pulses of the wrong length or spacing. The bench counts gate cycles over full 2·P windows and measures rise-to-rise distances, so such a fault is caught in the first measured window. A duty register loaded outside a vertex creates a pulse whose length is not a sum of two consecutive duties, and the run-length monitor catches this within a few periods of the write. A stuck trip latch or a wrong interrupt divider changes the gates or irq on the very next cycle, or within N·P cycles, and both are checked cycle by cycle.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

    localparam int CARRIER_W = 16;
    localparam int ADDR_W    = 3;

    typedef logic [CARRIER_W-1:0] carrier_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_PEAK    = 3'd0,
        REG_DUTY0   = 3'd1,
        REG_DUTY1   = 3'd2,
        REG_DUTY2   = 3'd3,
        REG_IRQ_DIV = 3'd4,
        REG_PROT    = 3'd5,
        REG_CMD     = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } gate_pair_t;

    // Centre-aligned window: inclusive while rising, exclusive while falling,
    // so each half-period contributes exactly duty cycles.
    function automatic logic carrier_below(input logic rising,
                                           input carrier_t cnt,
                                           input carrier_t duty);
        return rising ? (cnt <= duty) : (cnt < duty);
    endfunction

endpackage

// File: rtl/pwm3_carrier.sv
module pwm3_carrier
    import pwm3_pkg::*;
#(
    parameter carrier_t PEAK_RST = carrier_t'(1000)
) (
    input  logic     clk,
    input  logic     rst,
    input  carrier_t peak_shadow,
    output carrier_t count,
    output logic     rising,
    output carrier_t peak_act,
    output logic     vertex
);
    logic at_valley;
    logic at_top;

    assign at_valley = !rising && (count == '0);
    assign at_top    = rising && (count >= peak_act);
    assign vertex    = at_valley || at_top;

    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            rising   <= 1'b0;
            peak_act <= PEAK_RST;
        end else begin
            if (at_valley) begin
                peak_act <= peak_shadow;
            end
            if (at_top) begin
                rising <= 1'b0;
                count  <= count - 1'b1;
            end else if (at_valley) begin
                rising <= 1'b1;
                count  <= count + 1'b1;
            end else if (rising) begin
                count  <= count + 1'b1;
            end else begin
                count  <= count - 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwm3_leg.sv
module pwm3_leg
    import pwm3_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rising,
    input  carrier_t        count,
    input  carrier_t        duty,
    input  logic [DT_W-1:0] dead,
    output gate_pair_t      gates
);
    logic            want_hi;
    logic            state_q;
    logic [DT_W-1:0] gap_q;

    assign want_hi = carrier_below(rising, count, duty);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= 1'b0;
            gap_q   <= '0;
        end else begin
            state_q <= want_hi;
            if (want_hi != state_q) begin
                gap_q <= dead;
            end else if (gap_q != '0) begin
                gap_q <= gap_q - 1'b1;
            end
        end
    end

    always_comb begin
        gates.hi = state_q  && (gap_q == '0);
        gates.lo = !state_q && (gap_q == '0);
    end
endmodule

// File: rtl/pwm3_irq.sv
module pwm3_irq #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vertex,
    input  logic [DIV_W-1:0] divisor,
    input  logic             ack,
    output logic             irq
);
    logic [DIV_W-1:0] seen_q;
    logic             fire;

    assign fire = vertex && (divisor != '0) && (seen_q >= divisor - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
            irq    <= 1'b0;
        end else begin
            if (vertex) begin
                seen_q <= (fire || divisor == '0) ? '0 : seen_q + 1'b1;
            end
            irq <= fire || (irq && !ack);
        end
    end
endmodule

// File: rtl/pwm3_top.sv
module pwm3_top
    import pwm3_pkg::*;
#(
    parameter int       N_LEG    = 3,
    parameter int       DT_W     = 8,
    parameter int       DIV_W    = 8,
    parameter carrier_t PEAK_RST = carrier_t'(1000)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [CARRIER_W-1:0] wr_data,
    input  logic [DT_W-1:0]      dead_cfg,
    input  logic                 fault_in,
    output logic [N_LEG-1:0]     gate_hi,
    output logic [N_LEG-1:0]     gate_lo,
    output logic                 irq
);
    localparam int DUTY_BASE = int'(REG_DUTY0);

    carrier_t         peak_shadow;
    carrier_t         carrier_cnt;
    carrier_t         peak_act;
    logic             carrier_up;
    logic             vertex;
    logic [DIV_W-1:0] irq_div;
    logic             prot_en;
    logic             trip_q;
    logic             trip_clr;
    logic             irq_ack;
    carrier_t         duty_act [N_LEG];

    assign trip_clr = wr_en && (wr_addr == REG_CMD) && wr_data[0];
    assign irq_ack  = wr_en && (wr_addr == REG_CMD) && wr_data[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            peak_shadow <= PEAK_RST;
            irq_div     <= '0;
            prot_en     <= 1'b1;
        end else if (wr_en) begin
            case (wr_addr)
                REG_PEAK:    peak_shadow <= (wr_data == '0) ? carrier_t'(1) : wr_data;
                REG_IRQ_DIV: irq_div     <= wr_data[DIV_W-1:0];
                REG_PROT:    prot_en     <= wr_data[0];
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trip_q <= 1'b0;
        end else if (prot_en && fault_in) begin
            trip_q <= 1'b1;
        end else if (trip_clr) begin
            trip_q <= 1'b0;
        end
    end

    pwm3_carrier #(.PEAK_RST(PEAK_RST)) u_carrier (
        .clk        (clk),
        .rst        (rst),
        .peak_shadow(peak_shadow),
        .count      (carrier_cnt),
        .rising     (carrier_up),
        .peak_act   (peak_act),
        .vertex     (vertex)
    );

    for (genvar i = 0; i < N_LEG; i++) begin : g_leg
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(DUTY_BASE + i);
        carrier_t   duty_shadow;
        gate_pair_t pair;

        always_ff @(posedge clk) begin
            if (rst) begin
                duty_shadow <= '0;
                duty_act[i] <= '0;
            end else begin
                if (wr_en && wr_addr == MY_ADDR) begin
                    duty_shadow <= wr_data;
                end
                if (vertex) begin
                    duty_act[i] <= duty_shadow;
                end
            end
        end

        pwm3_leg #(.DT_W(DT_W)) u_leg (
            .clk   (clk),
            .rst   (rst),
            .rising(carrier_up),
            .count (carrier_cnt),
            .duty  (duty_act[i]),
            .dead  (dead_cfg),
            .gates (pair)
        );

        assign gate_hi[i] = pair.hi && !trip_q;
        assign gate_lo[i] = pair.lo && !trip_q;
    end

    pwm3_irq #(.DIV_W(DIV_W)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .vertex (vertex),
        .divisor(irq_div),
        .ack    (irq_ack),
        .irq    (irq)
    );
endmodule

// File: rtl/pwm3_chk.sv
module pwm3_chk
    import pwm3_pkg::*;
#(
    parameter int N_LEG = 3,
    parameter int DT_W  = 8
) (
    input logic            clk,
    input logic            rst,
    input logic [N_LEG-1:0] gate_hi,
    input logic [N_LEG-1:0] gate_lo,
    input logic            irq,
    input logic            irq_ack,
    input logic            fault_in,
    input logic            prot_en,
    input logic            trip_q,
    input logic            trip_clr,
    input logic            vertex,
    input carrier_t        carrier_cnt,
    input carrier_t        peak_act,
    input logic [DT_W-1:0] dead_cfg
);
    // R5
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        (gate_hi & gate_lo) == '0);

    // R5
    dead_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(gate_hi[0]) && dead_cfg != '0) |-> !$past(gate_lo[0]));

    // R7
    trip_block_chk: assert property (@(posedge clk) disable iff (rst)
        (prot_en && fault_in) |=> (gate_hi == '0 && gate_lo == '0));

    // R7
    trip_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (trip_q && !trip_clr) |=> trip_q);

    // R1
    carrier_range_chk: assert property (@(posedge clk) disable iff (rst)
        carrier_cnt <= peak_act);

    // R9
    irq_level_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_ack) |=> irq);

    // R9
    irq_vertex_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(vertex));
endmodule

bind pwm3_top pwm3_chk #(.N_LEG(N_LEG), .DT_W(DT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .gate_hi    (gate_hi),
    .gate_lo    (gate_lo),
    .irq        (irq),
    .irq_ack    (irq_ack),
    .fault_in   (fault_in),
    .prot_en    (prot_en),
    .trip_q     (trip_q),
    .trip_clr   (trip_clr),
    .vertex     (vertex),
    .carrier_cnt(carrier_cnt),
    .peak_act   (peak_act),
    .dead_cfg   (dead_cfg)
);

// File: tb/pwm3_top_bench.sv
module pwm3_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 3;
    localparam int P  = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  dead_cfg = 8'd2;
    logic        fault_in = 1'b0;
    logic [NL-1:0] gate_hi;
    logic [NL-1:0] gate_lo;
    logic        irq;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    int hi_cnt [NL];
    int lo_cnt [NL];
    int overlap;

    pwm3_top u_pwm3_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dead_cfg(dead_cfg), .fault_in(fault_in),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    task automatic write_reg(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(addr); wr_data = 16'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic measure(input int win);
        overlap = 0;
        for (int l = 0; l < NL; l++) begin hi_cnt[l] = 0; lo_cnt[l] = 0; end
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            for (int l = 0; l < NL; l++) begin
                hi_cnt[l] += int'(gate_hi[l]);
                lo_cnt[l] += int'(gate_lo[l]);
            end
            if ((gate_hi & gate_lo) != '0) overlap++;
        end
    endtask

    task automatic set_duty(input int a, input int b, input int c);
        write_reg(1, a); write_reg(2, b); write_reg(3, c);
        idle(6 * P);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        check("R10 upper gates after reset", int'(gate_hi), 0);
        check("R10 lower gates after reset", int'(gate_lo), 7);
        check("R10 irq after reset", int'(irq), 0);
        write_reg(0, P);
        idle(4 * 1000);
    endtask

    task automatic t_duty();
        set_duty(3, 5, 0);
        measure(2 * P);
        check("R2 leg0 upper on-time", hi_cnt[0], 4);
        check("R2 leg1 upper on-time", hi_cnt[1], 8);
        check("R2 leg0 lower on-time", lo_cnt[0], 12);
        check("R2 leg1 lower on-time", lo_cnt[1], 8);
        check("R3 zero duty upper", hi_cnt[2], 0);
        check("R3 zero duty lower", lo_cnt[2], 2 * P);
        check("R5 overlap cycles", overlap, 0);
    endtask

    task automatic t_full();
        set_duty(P, 200, 0);
        measure(2 * P);
        check("R3 duty at peak upper", hi_cnt[0], 2 * P);
        check("R3 duty at peak lower", lo_cnt[0], 0);
        check("R3 duty above peak upper", hi_cnt[1], 2 * P);
        check("R3 duty above peak lower", lo_cnt[1], 0);
    endtask

    task automatic t_nodead();
        int comp_bad;
        dead_cfg = 8'd0;
        set_duty(3, 7, 0);
        measure(2 * P);
        check("R6 leg0 upper", hi_cnt[0], 6);
        check("R6 leg1 upper", hi_cnt[1], 14);
        check("R6 leg1 lower", lo_cnt[1], 6);
        comp_bad = 0;
        for (int i = 0; i < 4 * P; i++) begin
            @(negedge clk);
            if ((gate_hi ^ gate_lo) != 3'b111) comp_bad++;
        end
        check("R6 complementary cycles violated", comp_bad, 0);
        dead_cfg = 8'd2;
        idle(2 * P);
    endtask

    task automatic t_vertex();
        int run;
        int armed;
        int bad;
        int next_d;
        set_duty(3, 0, 0);
        run = 0; armed = 0; bad = 0; next_d = 6;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (gate_hi[0]) begin
                run++;
            end else begin
                if (armed != 0 && run > 0) begin
                    n_checks++;
                    if (run != 4 && run != 10 && run != 7) begin
                        n_errors++;
                        bad++;
                        $display("FAIL R4 pulse length: actual %0d expected 4, 7 or 10", run);
                    end
                end
                run = 0;
                armed = 1;
            end
            if (i % 37 == 5) begin
                wr_en = 1'b1; wr_addr = 3'd1; wr_data = 16'(next_d);
                next_d = (next_d == 6) ? 3 : 6;
            end else begin
                wr_en = 1'b0;
            end
        end
        wr_en = 1'b0;
        check("R4 bad pulses", bad, 0);
    endtask

    task automatic t_period();
        int t0;
        set_duty(3, 0, 0);
        while (gate_hi[0]) @(negedge clk);
        while (!gate_hi[0]) @(negedge clk);
        t0 = cyc;
        while (gate_hi[0]) @(negedge clk);
        while (!gate_hi[0]) @(negedge clk);
        check("R1 period at peak 10", cyc - t0, 2 * P);
        write_reg(0, 7);
        idle(6 * P);
        while (gate_hi[0]) @(negedge clk);
        while (!gate_hi[0]) @(negedge clk);
        t0 = cyc;
        while (gate_hi[0]) @(negedge clk);
        while (!gate_hi[0]) @(negedge clk);
        check("R1 period at peak 7", cyc - t0, 14);
        write_reg(0, 0);
        write_reg(1, 1);
        idle(6 * P);
        measure(2 * P);
        check("R1 zero peak stored as one", hi_cnt[0], 2 * P);
        write_reg(0, P);
        set_duty(3, 5, 0);
    endtask

    task automatic t_irq();
        int t0;
        int drops;
        write_reg(4, 3);
        write_reg(6, 2);
        while (!irq) @(negedge clk);
        t0 = cyc;
        write_reg(6, 2);
        check("R9 ack clears irq", int'(irq), 0);
        while (!irq) @(negedge clk);
        check("R9 interval N*P", cyc - t0, 3 * P);
        drops = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (!irq) drops++;
        end
        check("R9 irq held without ack", drops, 0);
        write_reg(4, 0);
        write_reg(6, 2);
        drops = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (irq) drops++;
        end
        check("R9 divisor zero raises nothing", drops, 0);
    endtask

    task automatic t_fault();
        int live;
        set_duty(3, 5, 0);
        @(negedge clk); fault_in = 1'b1;
        @(negedge clk); fault_in = 1'b0;
        check("R7 gates off after fault", int'(gate_hi) + int'(gate_lo), 0);
        measure(4 * P);
        check("R7 upper stays off", hi_cnt[0] + hi_cnt[1] + hi_cnt[2], 0);
        check("R7 lower stays off", lo_cnt[0] + lo_cnt[1] + lo_cnt[2], 0);
        fault_in = 1'b1;
        write_reg(6, 1);
        fault_in = 1'b0;
        measure(4 * P);
        check("R7 clear ignored during fault", lo_cnt[2], 0);
        write_reg(6, 1);
        measure(2 * P);
        check("R7 lower gate resumes after clear", lo_cnt[2], 2 * P);
        write_reg(5, 0);
        fault_in = 1'b1;
        live = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            live += int'(gate_lo[2]);
        end
        fault_in = 1'b0;
        check("R8 fault ignored when disabled", live, 10);
        write_reg(5, 1);
    endtask

    initial begin
        t_reset();
        t_duty();
        t_full();
        t_nodead();
        t_vertex();
        t_period();
        t_irq();
        t_fault();
        summary();
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule